// File: doc/BRIEF.md
# Power-Down and Wake-Up Sequencer

This block controls the chip-wide low-power state. Software arms a power-down request by setting a bit in a small control register. The block enters power-down only when the CPU also reports that it is asleep. While powered down, the block forces off these outputs:

- the high-speed crystal and high-speed RC oscillator enables,
- the regulator enable,
- the PLL enable,
- the system clock enable.

The two low-speed oscillators keep the settings that software gave them.

Any wake source brings the block out of power-down. If the settling option is on, the block then holds the system clock off for a fixed number of cycles. That number depends on which high-speed source drives the system clock. The block keeps a sticky wake flag that software clears by writing 1, and it raises an interrupt when that flag and its enable are both set. The control register is writable only while the external lock indication reports it open. That indication comes from an unlock decoder that lives outside this block.

The register port has one address bit:

- Address 0 is the control register.
- Address 1 is the status register.

Reads return data combinationally from `reg_addr`.

Top module: `pdwk_ctrl`

## Requirements
- R1: The block enters power-down (`in_pd`=1, one cycle after the clock edge) only at a clock edge where the arm bit (control bit 0) is 1 and `cpu_sleep` is 1. Arming alone leaves the block running.
- R2: The arm bit is cleared by hardware on the edge at which the block leaves power-down, and it reads back as 0 afterwards.
- R3: While in power-down, `hs_xtal_on`, `hs_rc_on`, `ldo_on`, `pll_on` and `sys_clk_en` are all 0. `ls_xtal_on` and `ls_rc_on` follow control bits 6 and 5 unchanged.
- R4: With the delay bit (control bit 2) clear, `sys_clk_en` is 1 in the first cycle after the edge that sampled the wake event.
- R5: With the delay bit set, `sys_clk_en` stays 0 for exactly 16 cycles after the wake edge when `xtal_is_src`=0, and for exactly 4096 cycles when `xtal_is_src`=1.
- R6: Any nonzero `wake_src` bit sets the wake flag (status bit 0) in any state. Writing 1 to status bit 0 clears the flag. A set in the same cycle wins over the clear.
- R7: `wake_irq` is 1 exactly when the wake flag and the interrupt-enable bit (control bit 1) are both 1.
- R8: Writes to the control register take effect only while `unlocked`=1. Control bits: 0 arm, 1 interrupt enable, 2 delay enable, 3 high-speed RC, 4 high-speed crystal, 5 low-speed RC, 6 low-speed crystal. Bit 7 always reads 0.
- R9: After reset the control register reads 0x28 (both RC oscillators on, both crystals off), the status register reads 0, and the block runs with `sys_clk_en`=1.
- R10: A wake event while armed but with the CPU awake sets the wake flag, leaves the block running, and keeps the arm bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| unlocked | input | 1 | Protected-register lock is open |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = control, 1 = status |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| cpu_sleep | input | 1 | CPU reports sleep |
| wake_src | input | WAKE_N | Wake event lines, one per source |
| xtal_is_src | input | 1 | System clock comes from the high-speed crystal |
| hs_xtal_on | output | 1 | High-speed crystal enable |
| hs_rc_on | output | 1 | High-speed RC oscillator enable |
| ls_xtal_on | output | 1 | Low-speed crystal enable |
| ls_rc_on | output | 1 | Low-speed RC oscillator enable |
| ldo_on | output | 1 | Regulator enable |
| pll_on | output | 1 | PLL enable |
| sys_clk_en | output | 1 | CPU, AHB and APB clock enable |
| wake_irq | output | 1 | Wake interrupt |
| in_pd | output | 1 | Block is in power-down |

## Verification
The bench checks that arming alone never reaches power-down: a design that ignored `cpu_sleep` would drop the system clock as soon as the arm bit was written. It counts the held-off cycles after wake for both clock sources. An off-by-one load or a swapped length selection shows up as 15, 17 or the wrong one of 16 and 4096. Several checks read the arm bit back after wake: a design that did not clear it would sink straight back into power-down while the CPU still reports sleep. Other checks cover a wake event with the CPU awake, and writes made with the lock closed. The first would catch a design that slept or dropped the flag. The second would catch a design that let protected bits change.

// File: rtl/pdwk_pkg.sv
package pdwk_pkg;

  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_PD   = 2'd1,
    ST_WAIT = 2'd2
  } pd_state_t;

  localparam int CTRL_W     = 7;
  localparam int B_ARM      = 0;
  localparam int B_IE       = 1;
  localparam int B_DLY      = 2;
  localparam int B_HRC      = 3;
  localparam int B_HXT      = 4;
  localparam int B_LRC      = 5;
  localparam int B_LXT      = 6;
  localparam logic [CTRL_W-1:0] CTRL_RST = 7'h28;

  function automatic int wake_cycles(input logic xtal, input int xtal_len, input int rc_len);
    return xtal ? xtal_len : rc_len;
  endfunction

endpackage

// File: rtl/pdwk_regs.sv
module pdwk_regs
  import pdwk_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              unlocked,
  input  logic              reg_wr,
  input  logic              reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  input  logic              wake_any,
  input  logic              exit_pd,
  output logic [CTRL_W-1:0] ctrl,
  output logic              wake_flag,
  output logic [DW-1:0]     reg_rdata
);

  logic ctrl_wr, stat_clr;
  logic unused_hi;

  assign ctrl_wr   = reg_wr && !reg_addr && unlocked;
  assign stat_clr  = reg_wr && reg_addr && reg_wdata[0];
  assign unused_hi = ^reg_wdata[DW-1:CTRL_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= CTRL_RST;
    end else begin
      if (ctrl_wr) ctrl <= reg_wdata[CTRL_W-1:0];
      if (exit_pd) ctrl[B_ARM] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        wake_flag <= 1'b0;
    else if (wake_any) wake_flag <= 1'b1;
    else if (stat_clr) wake_flag <= 1'b0;
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr) reg_rdata[0] = wake_flag;
    else          reg_rdata[CTRL_W-1:0] = ctrl;
  end

endmodule

// File: rtl/pdwk_dly_cnt.sv
module pdwk_dly_cnt #(
  parameter int CW = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          run,
  output logic          done
);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt <= '0;
    else if (load)            cnt <= load_val;
    else if (run && cnt != 0) cnt <= cnt - 1'b1;
  end

  assign done = run && (cnt == {{(CW-1){1'b0}}, 1'b1});

endmodule

// File: rtl/pdwk_fsm.sv
module pdwk_fsm
  import pdwk_pkg::*;
#(
  parameter int XTAL_DLY = 4096,
  parameter int RC_DLY   = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic dly_en,
  input  logic cpu_sleep,
  input  logic wake_any,
  input  logic xtal_is_src,
  output pd_state_t state,
  output logic enter_pd,
  output logic exit_pd
);

  localparam int MAXD = (XTAL_DLY > RC_DLY) ? XTAL_DLY : RC_DLY;
  localparam int CW   = $clog2(MAXD + 1);

  pd_state_t nxt;
  logic dly_done, dly_load;
  logic [CW-1:0] dly_len;

  assign enter_pd = (state == ST_RUN) && arm && cpu_sleep;
  assign exit_pd  = (state == ST_PD) && wake_any;
  assign dly_load = exit_pd && dly_en;
  assign dly_len  = CW'(wake_cycles(xtal_is_src, XTAL_DLY, RC_DLY));

  always_comb begin
    nxt = state;
    case (state)
      ST_RUN:  if (enter_pd) nxt = ST_PD;
      ST_PD:   if (exit_pd)  nxt = dly_en ? ST_WAIT : ST_RUN;
      ST_WAIT: if (dly_done) nxt = ST_RUN;
      default: nxt = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_RUN;
    else        state <= nxt;
  end

  pdwk_dly_cnt #(.CW(CW)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (dly_load),
    .load_val (dly_len),
    .run      (state == ST_WAIT),
    .done     (dly_done)
  );

endmodule

// File: rtl/pdwk_gate.sv
module pdwk_gate
  import pdwk_pkg::*;
(
  input  pd_state_t         state,
  input  logic [CTRL_W-1:0] ctrl,
  input  logic              wake_flag,
  output logic              hs_xtal_on,
  output logic              hs_rc_on,
  output logic              ls_xtal_on,
  output logic              ls_rc_on,
  output logic              ldo_on,
  output logic              pll_on,
  output logic              sys_clk_en,
  output logic              wake_irq,
  output logic              in_pd
);

  logic asleep;
  logic unused_ctl;

  assign asleep     = (state == ST_PD);
  assign in_pd      = asleep;
  assign hs_xtal_on = ctrl[B_HXT] && !asleep;
  assign hs_rc_on   = ctrl[B_HRC] && !asleep;
  assign ls_xtal_on = ctrl[B_LXT];
  assign ls_rc_on   = ctrl[B_LRC];
  assign ldo_on     = !asleep;
  assign pll_on     = !asleep;
  assign sys_clk_en = (state == ST_RUN);
  assign wake_irq   = wake_flag && ctrl[B_IE];
  assign unused_ctl = ctrl[B_ARM] ^ ctrl[B_DLY];

endmodule

// File: rtl/pdwk_ctrl.sv
module pdwk_ctrl
  import pdwk_pkg::*;
#(
  parameter int DW       = 8,
  parameter int WAKE_N   = 9,
  parameter int XTAL_DLY = 4096,
  parameter int RC_DLY   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              unlocked,
  input  logic              reg_wr,
  input  logic              reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  input  logic              cpu_sleep,
  input  logic [WAKE_N-1:0] wake_src,
  input  logic              xtal_is_src,
  output logic              hs_xtal_on,
  output logic              hs_rc_on,
  output logic              ls_xtal_on,
  output logic              ls_rc_on,
  output logic              ldo_on,
  output logic              pll_on,
  output logic              sys_clk_en,
  output logic              wake_irq,
  output logic              in_pd
);

  logic [CTRL_W-1:0] ctrl;
  logic wake_flag, wake_any, enter_pd, exit_pd;
  pd_state_t state;

  assign wake_any = |wake_src;

  pdwk_regs #(.DW(DW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .unlocked  (unlocked),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .wake_any  (wake_any),
    .exit_pd   (exit_pd),
    .ctrl      (ctrl),
    .wake_flag (wake_flag),
    .reg_rdata (reg_rdata)
  );

  pdwk_fsm #(.XTAL_DLY(XTAL_DLY), .RC_DLY(RC_DLY)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .arm         (ctrl[B_ARM]),
    .dly_en      (ctrl[B_DLY]),
    .cpu_sleep   (cpu_sleep),
    .wake_any    (wake_any),
    .xtal_is_src (xtal_is_src),
    .state       (state),
    .enter_pd    (enter_pd),
    .exit_pd     (exit_pd)
  );

  pdwk_gate u_gate (
    .state      (state),
    .ctrl       (ctrl),
    .wake_flag  (wake_flag),
    .hs_xtal_on (hs_xtal_on),
    .hs_rc_on   (hs_rc_on),
    .ls_xtal_on (ls_xtal_on),
    .ls_rc_on   (ls_rc_on),
    .ldo_on     (ldo_on),
    .pll_on     (pll_on),
    .sys_clk_en (sys_clk_en),
    .wake_irq   (wake_irq),
    .in_pd      (in_pd)
  );

endmodule

// File: rtl/pdwk_chk.sv
module pdwk_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_pd,
  input logic       cpu_sleep,
  input logic       arm,
  input logic       dly_en,
  input logic       exit_pd,
  input logic       enter_pd,
  input logic       wake_any,
  input logic       wake_flag,
  input logic       unlocked,
  input logic [6:0] ctrl,
  input logic       sys_clk_en,
  input logic       hs_xtal_on,
  input logic       hs_rc_on,
  input logic       pll_on,
  input logic       ldo_on
);

  assert_enter_needs_sleep_R1: assert property (@(posedge clk) disable iff (!rst_n)
    enter_pd |=> in_pd && $past(cpu_sleep) && $past(arm));

  assert_arm_cleared_R2: assert property (@(posedge clk) disable iff (!rst_n)
    exit_pd |=> !arm && !in_pd);

  assert_gated_in_pd_R3: assert property (@(posedge clk) disable iff (!rst_n)
    in_pd |-> !sys_clk_en && !hs_xtal_on && !hs_rc_on && !pll_on && !ldo_on);

  assert_fast_restore_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (exit_pd && !dly_en) |=> sys_clk_en);

  assert_held_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (exit_pd && dly_en) |=> !sys_clk_en);

  assert_flag_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wake_any |=> wake_flag);

  assert_locked_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!unlocked && !exit_pd) |=> $stable(ctrl));

endmodule

bind pdwk_ctrl pdwk_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_pd      (in_pd),
  .cpu_sleep  (cpu_sleep),
  .arm        (ctrl[0]),
  .dly_en     (ctrl[2]),
  .exit_pd    (exit_pd),
  .enter_pd   (enter_pd),
  .wake_any   (wake_any),
  .wake_flag  (wake_flag),
  .unlocked   (unlocked),
  .ctrl       (ctrl),
  .sys_clk_en (sys_clk_en),
  .hs_xtal_on (hs_xtal_on),
  .hs_rc_on   (hs_rc_on),
  .pll_on     (pll_on),
  .ldo_on     (ldo_on)
);

// File: tb/sim_pdwk_ctrl.sv
module sim_pdwk_ctrl;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic unlocked = 1'b0, reg_wr = 1'b0, reg_addr = 1'b0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic cpu_sleep = 1'b0, xtal_is_src = 1'b0;
  logic [8:0] wake_src = '0;
  logic hs_xtal_on, hs_rc_on, ls_xtal_on, ls_rc_on, ldo_on, pll_on, sys_clk_en, wake_irq, in_pd;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  pdwk_ctrl u0 (.*);

  // {unlocked, write data, expected control readback}
  localparam logic [16:0] VEC [6] = '{
    {1'b1, 8'h3C, 8'h3C},
    {1'b0, 8'h00, 8'h3C},
    {1'b1, 8'h41, 8'h41},
    {1'b0, 8'hFF, 8'h41},
    {1'b1, 8'hFF, 8'h7F},
    {1'b1, 8'h28, 8'h28}
  };

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  function automatic int rd(input logic a);
    reg_addr = a;
    return 0;
  endfunction

  task automatic read(input logic a, output int v);
    @(negedge clk);
    reg_addr = a; #0.5;
    v = int'(reg_rdata);
  endtask

  task automatic sleep_now();
    @(negedge clk); cpu_sleep = 1'b1;
    @(posedge clk); #1;
  endtask

  task automatic pulse_wake(input logic [8:0] w);
    @(negedge clk); wake_src = w;
    @(posedge clk); #1;
    wake_src = '0;
  endtask

  task automatic count_hold(output int n);
    n = 0;
    while (!sys_clk_en && n < 5000) begin
      @(posedge clk); #1;
      n++;
    end
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int v, n;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk); #1;

    // R9 reset state
    read(1'b0, v); check("R9 ctrl", v, 'h28);
    read(1'b1, v); check("R9 status", v, 0);
    check("R9 clk", sys_clk_en, 1);
    check("R9 rc", {hs_rc_on, ls_rc_on, hs_xtal_on, ls_xtal_on}, 4'b1100);

    // R8 protected writes, table walk
    for (int i = 0; i < 6; i++) begin
      @(negedge clk) unlocked = VEC[i][16];
      wr(1'b0, VEC[i][15:8]);
      read(1'b0, v);
      check("R8 ctrl write", v, int'(VEC[i][7:0]));
    end

    // R1 arming alone does not sleep
    @(negedge clk) unlocked = 1'b1;
    wr(1'b0, 8'h29);
    repeat (4) @(posedge clk); #1;
    check("R1 armed awake", in_pd, 0);

    // R10 wake while armed but awake
    pulse_wake(9'h001);
    check("R10 stay run", sys_clk_en, 1);
    read(1'b0, v); check("R10 arm kept", v, 'h29);
    read(1'b1, v); check("R10 flag", v, 1);
    wr(1'b1, 8'h01);
    read(1'b1, v); check("R6 w1c", v, 0);

    // R1 / R3 enter power-down
    sleep_now();
    check("R1 enter", in_pd, 1);
    check("R3 gated", {hs_rc_on, ldo_on, pll_on, sys_clk_en}, 0);
    check("R3 low-speed kept", ls_rc_on, 1);

    // R4 no delay; R2 arm cleared; R6 from another source; R7
    pulse_wake(9'h100);
    check("R4 restore", sys_clk_en, 1);
    check("R4 out of pd", in_pd, 0);
    read(1'b0, v); check("R2 arm clear", v, 'h28);
    check("R7 irq off", wake_irq, 0);
    wr(1'b0, 8'h2A);
    check("R7 irq on", wake_irq, 1);
    repeat (3) @(posedge clk); #1;
    check("R2 no resleep", in_pd, 0);
    wr(1'b1, 8'h01);
    check("R7 irq cleared", wake_irq, 0);

    // R6 set wins over clear
    @(negedge clk);
    wake_src = 9'h010; reg_wr = 1'b1; reg_addr = 1'b1; reg_wdata = 8'h01;
    @(posedge clk); #1;
    wake_src = '0; reg_wr = 1'b0;
    read(1'b1, v); check("R6 set wins", v, 1);
    wr(1'b1, 8'h01);

    // R5 delay with RC source
    @(negedge clk) xtal_is_src = 1'b0;
    wr(1'b0, 8'h2D);
    @(posedge clk); #1;
    check("R1 re-enter", in_pd, 1);
    pulse_wake(9'h004);
    check("R5 held", sys_clk_en, 0);
    check("R5 rc back on", hs_rc_on, 1);
    count_hold(n);
    check("R5 rc length", n, 16);

    // R5 delay with crystal source
    @(negedge clk) xtal_is_src = 1'b1;
    wr(1'b0, 8'h3D);
    @(posedge clk); #1;
    check("R3 xtal gated", {in_pd, hs_xtal_on}, 2'b10);
    pulse_wake(9'h020);
    count_hold(n);
    check("R5 xtal length", n, 4096);
    read(1'b0, v); check("R2 arm clear after delay", v, 'h3C);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule